// File: doc/BRIEF.md
# Programmable Oversampling Bit Timer

This block produces the timing strobes that a serial transmitter and receiver need. It runs from a one-cycle tick enable that an upstream prescaler supplies, and counts a programmable number of ticks per bit. Any ratio from 4 to 16 ticks per bit can be selected. A lower ratio gives a faster line from the same tick source. The block does not move data. Shifting, parity, framing and buffering belong to the neighbouring logic, which uses the strobes produced here.

The transmit side has a free-running bit strobe that runs only while the transmitter is enabled. The receive side waits while idle for a high-to-low transition on the line. It then restarts its tick count and checks the line at the centre of the start bit. If the line is back high at that point, the event is treated as noise and the receiver returns to idle. Otherwise it issues one sample strobe per bit at the bit centre, for a frame of `FRAME_BITS` bits, and then returns to idle.

The ratio setting is held in an internal register. That register follows the configuration input only while both the transmitter and the receiver are quiet, so a strobe train never changes period partway through.

Top module: `os_bit_timer`

## Requirements
- R1: After reset the strobes are low, the receiver is idle, and the held ratio is 16 ticks per bit. This ratio stays in use if the transmitter is enabled before the block first becomes idle.
- R2: Only bits [3:0] of `os_cfg` are decoded. Codes 0 to 3 select 16 ticks per bit, and codes 4 to 15 select that many ticks per bit. Bits [7:4] have no effect.
- R3: The held ratio loads from `os_cfg` only on a clock edge at which `tx_en` is low and the receiver is idle. A change of `os_cfg` during a strobe train leaves the period of that train unchanged.
- R4: While `tx_en` is high, `tx_bit_stb` pulses in the cycle after every T-th counted tick. Counting starts with the first tick sampled with `tx_en` high.
- R5: While `tx_en` is low, `tx_bit_stb` stays low and the transmit tick count is cleared.
- R6: When `rxd` falls while the receiver is idle, the ticks that follow are counted. In the cycle after the floor(T/2)-th tick, `rx_sample_stb` and `rx_start_stb` pulse together if `rxd` is low at that tick.
- R7: If `rxd` is high at that start-bit centre tick, no strobe is issued and `rx_busy` returns low.
- R8: After a valid start, `rx_sample_stb` alone pulses once every T ticks, `FRAME_BITS`-1 more times. `rx_busy` is high from the cycle after the falling edge until the cycle after the last strobe.
- R9: Transitions of `rxd` while the receiver is busy do not restart or shift the sample strobes.
- R10: Every strobe is high for exactly one clock cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle oversampling tick from the prescaler |
| os_cfg | input | CFG_W (8) | Ratio configuration register value |
| tx_en | input | 1 | Transmitter enable |
| rxd | input | 1 | Receive line, already synchronised to clk |
| tx_bit_stb | output | 1 | Transmit bit-period strobe |
| rx_sample_stb | output | 1 | Receive bit-centre sample strobe |
| rx_start_stb | output | 1 | Marks the sample strobe of a validated start bit |
| rx_busy | output | 1 | Receiver is timing a frame |

## Verification
The bench builds the block with `FRAME_BITS` set to 4 and `CFG_W` left at 8. It drives a tick on every second clock. Short frames mean that the end of every frame, the return to idle, and the next start all occur many times within a short run. The two-clock tick spacing separates the counted ticks from the clock edges on which each strobe appears. With the 8-bit configuration width, codes with upper bits set can be applied, as well as the aliased codes below 4 and the odd ratios, where the floor of half the ratio matters.

// File: rtl/os_timer_pkg.sv
// Package: os_timer_pkg
// Shared constants, types and the ratio decode for the oversampling bit timer.
// Assumes the ratio range 4..16 is fixed by the line protocol.
package os_timer_pkg;

    localparam int unsigned OS_MIN  = 4;
    localparam int unsigned OS_MAX  = 16;
    localparam int unsigned SEL_W   = 4;
    localparam int unsigned RATIO_W = $clog2(OS_MAX + 1);

    typedef logic [RATIO_W-1:0] ratio_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_RUN   = 2'd2
    } rx_state_e;

    // Map a 4-bit selection code to ticks per bit; small codes alias to the maximum.
    function automatic ratio_t decode_ratio(input logic [SEL_W-1:0] code);
        if (code < SEL_W'(OS_MIN)) begin
            return ratio_t'(OS_MAX);
        end
        return ratio_t'(code);
    endfunction

endpackage

// File: rtl/os_ratio_sel.sv
// Module: os_ratio_sel
// Holds the active ticks-per-bit ratio. It reloads from the configuration value
// only while the caller reports idle. Assumes cfg is a register value that is
// stable across clock edges.
module os_ratio_sel
    import os_timer_pkg::*;
#(
    parameter int unsigned CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             idle,
    output ratio_t           ratio
);

    localparam int unsigned HI_W = CFG_W - SEL_W;

    logic [HI_W-1:0] cfg_hi_unused;
    assign cfg_hi_unused = cfg[CFG_W-1:SEL_W];

    // Load the decoded ratio while idle; otherwise keep the one in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio <= ratio_t'(OS_MAX);
        end else if (idle) begin
            ratio <= decode_ratio(cfg[SEL_W-1:0]);
        end
    end

endmodule

// File: rtl/os_tx_timer.sv
// Module: os_tx_timer
// Free-running transmit bit timer. It pulses stb in the cycle after every
// ratio-th tick while en is high, and is held clear while en is low.
// Assumes ratio does not change while en is high.
module os_tx_timer
    import os_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   en,
    input  ratio_t ratio,
    output logic   stb
);

    ratio_t cnt;

    // Count ticks within the bit period and raise the strobe at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            stb <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (!en) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == ratio - ratio_t'(1)) begin
                    cnt <= '0;
                    stb <= 1'b1;
                end else begin
                    cnt <= cnt + ratio_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/os_rx_timer.sv
// Module: os_rx_timer
// Receive bit timer. It starts on a falling edge of the line while idle,
// checks the start bit half a bit later, and then issues a centre sample
// strobe each bit for FRAME_BITS bits. Assumes rxd is already synchronised
// and that ratio holds still while busy.
module os_rx_timer
    import os_timer_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 10
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   rxd,
    input  ratio_t ratio,
    output logic   sample_stb,
    output logic   start_stb,
    output logic   busy
);

    localparam int unsigned BIT_W = $clog2(FRAME_BITS + 1);

    rx_state_e  state;
    ratio_t     cnt;
    logic [BIT_W-1:0] bits;
    logic       rxd_q;
    ratio_t     half;
    logic       fall;

    assign half = ratio >> 1;
    assign fall = rxd_q & ~rxd;
    assign busy = (state != RX_IDLE);

    // Keep the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxd_q <= 1'b1;
        end else begin
            rxd_q <= rxd;
        end
    end

    // Frame sequencer: hunt for an edge, check the start bit, then time each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            bits       <= '0;
            sample_stb <= 1'b0;
            start_stb  <= 1'b0;
        end else begin
            sample_stb <= 1'b0;
            start_stb  <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt  <= '0;
                    bits <= '0;
                    if (fall) begin
                        state <= RX_START;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == half - ratio_t'(1)) begin
                            cnt <= '0;
                            if (!rxd) begin
                                sample_stb <= 1'b1;
                                start_stb  <= 1'b1;
                                bits       <= BIT_W'(1);
                                state      <= RX_RUN;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            cnt <= cnt + ratio_t'(1);
                        end
                    end
                end
                RX_RUN: begin
                    if (tick) begin
                        if (cnt == ratio - ratio_t'(1)) begin
                            cnt        <= '0;
                            sample_stb <= 1'b1;
                            if (bits == BIT_W'(FRAME_BITS - 1)) begin
                                state <= RX_IDLE;
                            end else begin
                                bits <= bits + BIT_W'(1);
                            end
                        end else begin
                            cnt <= cnt + ratio_t'(1);
                        end
                    end
                end
                default: begin
                    state <= RX_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/os_bit_timer.sv
// Module: os_bit_timer
// Top of the oversampling bit timer. It ties the ratio holder to the transmit
// and receive timers. The ratio reloads only when both sides are idle.
// Assumes tick_en is a one-cycle pulse from a prescaler in the same clock domain.
module os_bit_timer
    import os_timer_pkg::*;
#(
    parameter int unsigned CFG_W      = 8,
    parameter int unsigned FRAME_BITS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CFG_W-1:0] os_cfg,
    input  logic             tx_en,
    input  logic             rxd,
    output logic             tx_bit_stb,
    output logic             rx_sample_stb,
    output logic             rx_start_stb,
    output logic             rx_busy
);

    ratio_t ratio_q;
    logic   both_idle;

    assign both_idle = ~tx_en & ~rx_busy;

    os_ratio_sel #(
        .CFG_W (CFG_W)
    ) u_ratio (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (os_cfg),
        .idle  (both_idle),
        .ratio (ratio_q)
    );

    os_tx_timer u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .en    (tx_en),
        .ratio (ratio_q),
        .stb   (tx_bit_stb)
    );

    os_rx_timer #(
        .FRAME_BITS (FRAME_BITS)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .rxd        (rxd),
        .ratio      (ratio_q),
        .sample_stb (rx_sample_stb),
        .start_stb  (rx_start_stb),
        .busy       (rx_busy)
    );

endmodule

// File: rtl/os_bit_timer_chk.sv
// Module: os_bit_timer_chk
// Protocol checker for os_bit_timer, attached by bind. It watches the ports
// and the held ratio.
module os_bit_timer_chk
    import os_timer_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   tick_en,
    input logic   tx_en,
    input logic   tx_bit_stb,
    input logic   rx_sample_stb,
    input logic   rx_start_stb,
    input logic   rx_busy,
    input ratio_t ratio
);

    a_r2_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio >= ratio_t'(OS_MIN)) && (ratio <= ratio_t'(OS_MAX)));

    a_r3_ratio_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_busy) |=> $stable(ratio));

    a_r4_tx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_stb |-> $past(tick_en));

    a_r5_tx_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_bit_stb);

    a_r6_start_with_sample: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_stb |-> rx_sample_stb);

    a_r10_tx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_stb |=> !tx_bit_stb);

    a_r10_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample_stb |=> !rx_sample_stb);

    a_r6_rx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample_stb |-> $past(tick_en));

endmodule

bind os_bit_timer os_bit_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .tx_en         (tx_en),
    .tx_bit_stb    (tx_bit_stb),
    .rx_sample_stb (rx_sample_stb),
    .rx_start_stb  (rx_start_stb),
    .rx_busy       (rx_busy),
    .ratio         (ratio_q)
);

// File: tb/os_bit_timer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue the expected strobe cycles, and a
// monitor at the falling clock edge pops and compares them.
module os_bit_timer_tb;

    localparam int DIV = 2;
    localparam int FB  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_on = 1'b0;
    logic [7:0] os_cfg = 8'h05;
    logic       tx_en = 1'b1;
    logic       rxd = 1'b1;
    logic       tick_en;
    logic       tx_bit_stb, rx_sample_stb, rx_start_stb, rx_busy;

    int cyc = 0;
    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    int tx_q[$];
    int rx_q[$];
    bit rx_first_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign tick_en = tick_on && ((cyc % DIV) == 0);

    os_bit_timer #(.CFG_W(8), .FRAME_BITS(FB)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .os_cfg        (os_cfg),
        .tx_en         (tx_en),
        .rxd           (rxd),
        .tx_bit_stb    (tx_bit_stb),
        .rx_sample_stb (rx_sample_stb),
        .rx_start_stb  (rx_start_stb),
        .rx_busy       (rx_busy)
    );

    // Record one check and report a mismatch.
    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare every strobe against the head of its queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (tx_bit_stb) begin
                if (tx_q.size() == 0) check(1'b0, {cur_req, " unexpected tx strobe"}, cyc, -1);
                else begin
                    int e;
                    e = tx_q.pop_front();
                    check(cyc == e, {cur_req, " R4 tx strobe cycle"}, cyc, e);
                end
            end
            if (rx_sample_stb) begin
                if (rx_q.size() == 0) check(1'b0, {cur_req, " unexpected rx strobe"}, cyc, -1);
                else begin
                    int e;
                    bit f;
                    e = rx_q.pop_front();
                    f = rx_first_q.pop_front();
                    check(cyc == e, {cur_req, " R8 rx sample cycle"}, cyc, e);
                    check(rx_start_stb == f, {cur_req, " R6 start flag"}, int'(rx_start_stb), int'(f));
                end
            end else if (rx_start_stb) begin
                check(1'b0, {cur_req, " R6 start without sample"}, 1, 0);
            end
        end
    end

    // Queue n transmit strobes for ratio t, counting starts in cycle e.
    task automatic tx_expect(input int t, input int n, input int e);
        int t0, kt;
        t0 = e + ((DIV - (e % DIV)) % DIV);
        kt = t0 + (t - 1) * DIV;
        for (int j = 0; j < n; j++) tx_q.push_back(kt + 1 + j * t * DIV);
    endtask

    // Wait for both queues to empty, then confirm nothing is left over.
    task automatic drain(input int limit);
        int n;
        n = 0;
        while ((tx_q.size() != 0 || rx_q.size() != 0) && n < limit) begin
            @(negedge clk); #1;
            n++;
        end
        check(tx_q.size() == 0 && rx_q.size() == 0, {cur_req, " all expected strobes seen"},
              tx_q.size() + rx_q.size(), 0);
    endtask

    // Disable the transmitter and watch a quiet window (R5).
    task automatic tx_stop(input int t);
        @(negedge clk);
        tx_en = 1'b0;
        cur_req = "R5";
        repeat (3 * t * DIV) @(negedge clk);
        check(tx_bit_stb == 1'b0, "R5 tx quiet when disabled", int'(tx_bit_stb), 0);
    endtask

    // Apply a configuration code while idle and let it load.
    task automatic set_cfg(input logic [7:0] v);
        @(negedge clk);
        os_cfg = v;
        repeat (3) @(negedge clk);
    endtask

    // Run the transmitter for n bits at ratio t.
    task automatic tx_run(input int t, input int n, input string req);
        cur_req = req;
        @(negedge clk);
        tx_en = 1'b1;
        tx_expect(t, n, cyc);
        drain(n * t * DIV + 64);
        tx_stop(t);
    endtask

    // Drive one receive frame at ratio t; glitch aborts it, toggle adds mid-frame edges (R9).
    task automatic rx_frame(input int t, input bit glitch, input bit toggle, input logic [7:0] mid_cfg,
                            input string req);
        int f, t0, kh;
        cur_req = req;
        @(negedge clk);
        rxd = 1'b0;
        f = cyc;
        t0 = (f + 1) + ((DIV - ((f + 1) % DIV)) % DIV);
        kh = t0 + (t / 2 - 1) * DIV;
        if (glitch) begin
            @(negedge clk);
            rxd = 1'b1;                       // R7: line back high before the centre tick
            repeat (t * DIV + 4) @(negedge clk);
            check(rx_busy == 1'b0, "R7 receiver back to idle", int'(rx_busy), 0);
            check(rx_q.size() == 0, "R7 no strobes after glitch", rx_q.size(), 0);
        end else begin
            rx_q.push_back(kh + 1);
            rx_first_q.push_back(1'b1);
            for (int j = 1; j < FB; j++) begin
                rx_q.push_back(kh + 1 + j * t * DIV);
                rx_first_q.push_back(1'b0);
            end
            @(negedge clk);
            check(rx_busy == 1'b1, {req, " R8 busy during frame"}, int'(rx_busy), 1);
            os_cfg = mid_cfg;                 // R3: must not alter this frame
            if (toggle) begin
                while (cyc < kh + 3) @(negedge clk);
                rxd = 1'b1;                   // R9: extra edge while busy
                @(negedge clk);
                rxd = 1'b0;
            end
            drain(FB * t * DIV + 64);
            @(negedge clk);
            rxd = 1'b1;
            repeat (2) @(negedge clk);
            check(rx_busy == 1'b0, "R8 idle after last bit", int'(rx_busy), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick_on = 1'b1;
        repeat (5) @(negedge clk);
        check(tx_bit_stb == 0 && rx_sample_stb == 0 && rx_start_stb == 0, "R1 strobes low in reset",
              int'(tx_bit_stb | rx_sample_stb | rx_start_stb), 0);
        // R1: release reset with tx already on and cfg=5; the reset ratio 16 must apply.
        rst_n = 1'b1;
        tx_expect(16, 3, cyc);
        @(negedge clk);
        check(rx_busy == 1'b0, "R1 receiver idle after reset", int'(rx_busy), 0);
        drain(3 * 16 * DIV + 64);
        tx_stop(16);

        // R2: aliased, plain and upper-bit codes.
        set_cfg(8'h02); tx_run(16, 2, "R2 code 2");
        set_cfg(8'hF7); tx_run(7, 3, "R2 code F7");
        set_cfg(8'h0D); tx_run(13, 2, "R2 code D");
        set_cfg(8'h04); tx_run(4, 3, "R2 code 4");

        // R3: a change while transmitting keeps the old period, the new one applies after idle.
        cur_req = "R3";
        @(negedge clk);
        tx_en = 1'b1;
        tx_expect(4, 6, cyc);
        repeat (12) @(negedge clk);
        os_cfg = 8'h09;
        drain(6 * 4 * DIV + 64);
        tx_stop(4);
        repeat (3) @(negedge clk);
        tx_run(9, 2, "R3 new ratio after idle");

        // R6, R8 and R9: receive frames.
        rx_frame(9, 1'b0, 1'b1, 8'h06, "R9 frame T9");
        repeat (3) @(negedge clk);
        rx_frame(6, 1'b0, 1'b0, 8'h06, "R3 rx frame uses new T6");
        rx_frame(6, 1'b1, 1'b0, 8'h06, "R7 glitch T6");
        set_cfg(8'h07);
        rx_frame(7, 1'b0, 1'b0, 8'h07, "R6 odd T7");
        set_cfg(8'h00);
        rx_frame(16, 1'b0, 1'b0, 8'h00, "R6 T16");
        rx_frame(16, 1'b0, 1'b1, 8'h00, "R10 back to back T16");

        repeat (20) @(negedge clk);
        check(tx_q.size() == 0 && rx_q.size() == 0, "R10 no stray strobes", tx_q.size() + rx_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule